// File: doc/BRIEF.md
# RV64 Integer Execution Unit with Word Operations

This block is the integer arithmetic and logic stage of a 64-bit RISC-V pipeline. Each cycle it can accept one operation: two 64-bit operands, a 4-bit operation code and a word-mode flag. One clock later it returns the 64-bit result from an output register. Immediate forms need no special handling here. The decoder sign-extends the 12-bit immediate to 64 bits upstream and presents it as operand B.

The unit supports addition, subtraction, bitwise AND/OR/XOR, signed and unsigned set-less-than, and left-logical, right-logical and right-arithmetic shifts. When the word-mode flag is set, addition, subtraction and the three shifts run on the low 32 bits of operand A. In that mode they take a 5-bit shift amount and sign-extend their 32-bit result to 64 bits. The other operations ignore the flag. Branch resolution, memory access and multiply/divide belong to other units.

Top module: `rv_int_exec`

## Requirements
- R1: While `rst` is high at a rising edge, `res_valid` becomes 0 and `result` becomes all zeros.
- R2: A cycle with `in_valid` high sets `res_valid` and loads `result` at that rising edge. A cycle with `in_valid` low clears `res_valid` and leaves `result` unchanged.
- R3: Code 0 (add) gives A+B and code 1 (subtract) gives A−B, both modulo 2^64, with no overflow indication.
- R4: Code 9 gives A AND B, code 8 gives A OR B and code 5 gives A XOR B, bit by bit.
- R5: Code 3 gives 1 when A < B as two's-complement numbers and 0 otherwise, with bits 63:1 always zero.
- R6: Code 4 gives 1 when A < B as unsigned numbers and 0 otherwise, with bits 63:1 always zero.
- R7: Outside word mode, code 2 shifts A left with zero fill, code 6 shifts A right with zero fill, and code 7 shifts A right filling with bit 63. The amount is B[5:0], and B[63:6] has no effect.
- R8: In word mode, codes 0 and 1 compute the sum or difference of A[31:0] and B[31:0] modulo 2^32 and sign-extend it from bit 31.
- R9: In word mode, codes 2, 6 and 7 shift A[31:0] by B[4:0] and sign-extend the 32-bit result from bit 31. The arithmetic right shift fills with A[31], and A[63:32] and B[63:5] have no effect.
- R10: The word-mode flag has no effect on codes 3, 4, 5, 8 and 9.
- R11: Codes 10 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| word_mode | input | 1 | Select 32-bit word variant |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, already sign-extended when from an immediate |
| res_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
The bench crosses all sixteen codes and both modes with a set of operands chosen to break weak designs. The set includes zero, all ones, the signed extremes of both 64 and 32 bits, and values just around bit 31. Signed and unsigned comparisons disagree on these values, and a design that confused them returns the inverted bit. Each shift kind is swept over every amount from 0 to 63 in both modes, with junk in the upper bits of B. A design that masked too few or too many amount bits, filled a word arithmetic shift from bit 63, or forgot the 32-bit sign extension would return a wrong upper half. Idle cycles with changing inputs expose a result register that loads without a valid input.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;

  typedef enum logic [3:0] {
    OPC_ADD  = 4'd0,
    OPC_SUB  = 4'd1,
    OPC_SLL  = 4'd2,
    OPC_SLT  = 4'd3,
    OPC_SLTU = 4'd4,
    OPC_XOR  = 4'd5,
    OPC_SRL  = 4'd6,
    OPC_SRA  = 4'd7,
    OPC_OR   = 4'd8,
    OPC_AND  = 4'd9
  } exec_op_e;

  typedef enum logic [1:0] {
    LGC_AND = 2'd0,
    LGC_OR  = 2'd1,
    LGC_XOR = 2'd2
  } logic_fn_e;

  function automatic logic op_is_shift(logic [3:0] code);
    return (code == OPC_SLL) || (code == OPC_SRL) || (code == OPC_SRA);
  endfunction

  function automatic logic op_is_arith(logic [3:0] code);
    return (code == OPC_ADD) || (code == OPC_SUB);
  endfunction

endpackage

// File: rtl/rv_exec_addsub.sv
module rv_exec_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic [W-1:0] b_eff;
  logic         carry;

  always_comb begin
    b_eff        = sub ? ~b : b;
    {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    // With sub set, no carry out means a borrow: a < b unsigned.
    lt_unsigned  = sub & ~carry;
    lt_signed    = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
  end
endmodule

// File: rtl/rv_exec_logic.sv
module rv_exec_logic
  import rv_exec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      LGC_AND: y = a & b;
      LGC_OR:  y = a | b;
      LGC_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rv_exec_shift.sv
module rv_exec_shift #(
  parameter int W   = 64,
  parameter int AMW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [AMW-1:0] amt,
  input  logic           word,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   y
);
  localparam int HW = W / 2;

  logic [W-1:0]        src;
  logic [AMW-1:0]      amt_eff;
  logic signed [W:0]   ext;
  logic signed [W:0]   rshift;
  logic [W-1:0]        raw;

  always_comb begin
    // Word mode: rebuild the upper half from the low half so a single
    // full-width right shifter yields the correct 32-bit fill.
    if (word) begin
      src     = {{HW{arith & a[HW-1]}}, a[HW-1:0]};
      amt_eff = {1'b0, amt[AMW-2:0]};
    end else begin
      src     = a;
      amt_eff = amt;
    end
    ext    = {arith & src[W-1], src};
    rshift = ext >>> amt_eff;
    raw    = left ? (src << amt_eff) : rshift[W-1:0];
    y      = word ? {{HW{raw[HW-1]}}, raw[HW-1:0]} : raw;
  end
endmodule

// File: rtl/rv_int_exec.sv
module rv_int_exec
  import rv_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op_sel,
  input  logic            word_mode,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            res_valid,
  output logic [XLEN-1:0] result
);
  localparam int WLEN = XLEN / 2;
  localparam int AMW  = $clog2(XLEN);

  logic            use_sub;
  logic [XLEN-1:0] sum;
  logic            lt_s, lt_u;
  logic [XLEN-1:0] logic_y;
  logic_fn_e       lfn;
  logic [XLEN-1:0] shift_y;
  logic [XLEN-1:0] arith_y;
  logic [XLEN-1:0] next_res;

  assign use_sub = (op_sel == OPC_SUB) || (op_sel == OPC_SLT) || (op_sel == OPC_SLTU);

  rv_exec_addsub #(.W(XLEN)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(use_sub),
    .sum(sum), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  always_comb begin
    unique case (op_sel)
      OPC_OR:  lfn = LGC_OR;
      OPC_XOR: lfn = LGC_XOR;
      default: lfn = LGC_AND;
    endcase
  end

  rv_exec_logic #(.W(XLEN)) u_logic (
    .a(opnd_a), .b(opnd_b), .fn(lfn), .y(logic_y)
  );

  rv_exec_shift #(.W(XLEN), .AMW(AMW)) u_shift (
    .a(opnd_a), .amt(opnd_b[AMW-1:0]), .word(word_mode),
    .left(op_sel == OPC_SLL), .arith(op_sel == OPC_SRA), .y(shift_y)
  );

  assign arith_y = word_mode ? {{WLEN{sum[WLEN-1]}}, sum[WLEN-1:0]} : sum;

  always_comb begin
    unique case (op_sel)
      OPC_ADD, OPC_SUB:          next_res = arith_y;
      OPC_SLT:                   next_res = {{(XLEN-1){1'b0}}, lt_s};
      OPC_SLTU:                  next_res = {{(XLEN-1){1'b0}}, lt_u};
      OPC_AND, OPC_OR, OPC_XOR:  next_res = logic_y;
      OPC_SLL, OPC_SRL, OPC_SRA: next_res = shift_y;
      default:                   next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R2: result register loads only on valid input
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(result)));

  // R5 / R6: comparison results occupy bit 0 only
  assert_cmp_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OPC_SLT || op_sel == OPC_SLTU))
      |=> (result[XLEN-1:1] == '0));

  // R8: word add/sub upper half mirrors bit 31
  assert_word_sext_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_mode && op_is_arith(op_sel))
      |=> (result[XLEN-1:WLEN] == {WLEN{result[WLEN-1]}}));

  // R9: word shifts upper half mirrors bit 31
  assert_word_shift_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_mode && op_is_shift(op_sel))
      |=> (result[XLEN-1:WLEN] == {WLEN{result[WLEN-1]}}));

  // R11: unassigned codes give zero
  assert_bad_op_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel > 4'd9) |=> (result == '0));
endmodule

// File: tb/rv_int_exec_bench.sv
module rv_int_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op_sel;
  logic        word_mode;
  logic [63:0] opnd_a, opnd_b;
  logic        res_valid;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_int_exec u_rv_int_exec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .result(result)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(int op, logic w, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int sh;
    sh = w ? int'(b[4:0]) : int'(b[5:0]);
    case (op)
      0: begin r = a + b; if (w) r = sx32(r[31:0]); end
      1: begin r = a - b; if (w) r = sx32(r[31:0]); end
      2: begin
        r = a;
        for (int k = 0; k < sh; k++) r = {r[62:0], 1'b0};
        if (w) r = sx32(r[31:0]);
      end
      6: begin
        r = w ? {32'd0, a[31:0]} : a;
        for (int k = 0; k < sh; k++) r = {1'b0, r[63:1]};
        if (w) r = sx32(r[31:0]);
      end
      7: begin
        r = w ? sx32(a[31:0]) : a;
        for (int k = 0; k < sh; k++) r = {r[63], r[63:1]};
        if (w) r = sx32(r[31:0]);
      end
      3: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      4: r = (a < b) ? 64'd1 : 64'd0;
      5: r = a ^ b;
      8: r = a | b;
      9: r = a & b;
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(int op, logic w);
    case (op)
      0, 1:    return w ? "R8" : "R3";
      2, 6, 7: return w ? "R9" : "R7";
      3:       return w ? "R10 R5" : "R5";
      4:       return w ? "R10 R6" : "R6";
      5, 8, 9: return w ? "R10 R4" : "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(int op, logic w, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    op_sel    = op[3:0];
    word_mode = w;
    opnd_a    = a;
    opnd_b    = b;
    @(negedge clk);
    check(tag_of(op, w), result, model(op, w, a, b));
  endtask

  logic [63:0] vecs [10];

  initial begin
    vecs[0] = 64'h0;
    vecs[1] = 64'h1;
    vecs[2] = 64'hffff_ffff_ffff_ffff;
    vecs[3] = 64'h8000_0000_0000_0000;
    vecs[4] = 64'h7fff_ffff_ffff_ffff;
    vecs[5] = 64'h0000_0000_8000_0000;
    vecs[6] = 64'h0000_0000_7fff_ffff;
    vecs[7] = 64'hdead_beef_1234_5678;
    vecs[8] = 64'h20;
    vecs[9] = 64'h1f;

    rst = 1'b1; in_valid = 1'b1; op_sel = 4'd0; word_mode = 1'b0;
    opnd_a = 64'h5; opnd_b = 64'h7;
    repeat (3) @(negedge clk);
    check("R1 result", result, 64'd0);
    check("R1 res_valid", {63'd0, res_valid}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    // Full cross of codes, modes and operand pairs
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            run_op(op, w[0], vecs[i], vecs[j]);

    check("R2 valid after load", {63'd0, res_valid}, 64'd1);

    // Shift amount sweep with junk in the upper bits of B
    for (int op = 2; op < 8; op++) begin
      if (op == 2 || op == 6 || op == 7)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 64; s++) begin
            run_op(op, w[0], 64'h8123_4567_89ab_cdef, 64'hffff_ffff_ffff_ffc0 | 64'(s));
            run_op(op, w[0], 64'h1234_5678_8765_4321, 64'h0000_0000_0000_0040 | 64'(s));
          end
    end

    // Idle cycles: result holds, valid drops
    run_op(0, 1'b0, 64'd100, 64'd23);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 4'd9; opnd_a = 64'hffff; opnd_b = 64'h0;
    @(negedge clk);
    check("R2 hold result", result, 64'd123);
    check("R2 valid low", {63'd0, res_valid}, 64'd0);
    @(negedge clk);
    check("R2 hold result second idle", result, 64'd123);

    // Reset mid-run clears the register
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", result, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule